// File: doc/BRIEF.md
# Quad Core Wakeup Request Handler

This block takes special-wakeup requests aimed at a cluster of four cores, delivered over a 64-bit register bus. Bus addresses are byte addresses, and only 8-byte accesses occur. The block forms a 32-bit register index by shifting the address right by three. Bits are numbered MSB-first. Bits 16 to 19 of that index do not take part in register decode. Instead they act as a per-core select mask, so one register can target any subset of the four cores.

A write to the request register carries a set/clear value in data bit 0. Each selected core's wakeup request takes that value. The shared done flag also takes that value, whatever the mask holds. No power-state sequencing is modelled, so completion is reported at once. A read of the status register reports the done flag in two bit positions.

Top module: `qwk_handler`

## Requirements
- R1: After reset, all four entries of `wake_req` are 0, `wake_done` is 0, `rd_valid` is 0 and `unimpl_err` is 0.
- R2: The register index is `addr >> 3`. Decode compares the index with its bits 16..19 forced to zero. MSB-first numbering in a 32-bit index puts those bits at LSB positions 15..12.
- R3: A write whose decoded index is 0x83c sets `wake_req[j]` to the value of data bit 0, for every core j whose select bit 16+j is 1. Select bit 16+j sits at LSB position 15-j of the index. Data bit 0 in MSB-first numbering is LSB bit 63. Cores that are not selected keep their value. The new value is visible in the cycle after the write.
- R4: A write whose decoded index is 0x83c also sets `wake_done` to the value of data bit 0, whatever the select mask holds. With an all-zero mask, only `wake_done` changes.
- R5: A read whose decoded index is 0x82c returns zero, except that MSB-first bits 1 and 4 (LSB bits 62 and 59) are both 1 while the done flag is set.
- R6: A read of any other index returns all ones.
- R7: A write to any other index changes neither `wake_req` nor `wake_done`. It pulses `unimpl_err` high for exactly one cycle, in the cycle after the write.
- R8: Read data and `rd_valid` are presented in the cycle after the read request. `rd_valid` is high for exactly one cycle per read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 35 | Byte address |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 64 | Read data |
| wake_req | output | 4 | Per-core wakeup request, bit j = core j |
| wake_done | output | 1 | Shared wakeup-done flag |
| unimpl_err | output | 1 | One-cycle pulse on a write to an unknown register |

## Verification
Every result in this block appears exactly one clock edge after the request cycle. This covers wakeup request updates, the done flag, the unimplemented-write pulse, and read data with its valid strobe. The bench drives a request on a falling edge and lets one rising edge pass. It then samples on the following falling edge, where the registered outputs have settled. Checks that something holds for one cycle only, or that nothing changed, sample one more falling edge later.

// File: rtl/qwk_pkg.sv
package qwk_pkg;
  localparam int unsigned IDX_W    = 32;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned NCORE    = 4;
  localparam int unsigned SEL_MSB0 = 16;
  localparam logic [IDX_W-1:0] IDX_REQ  = 32'h0000_083c;
  localparam logic [IDX_W-1:0] IDX_STAT = 32'h0000_082c;

  function automatic int unsigned msb0(input int unsigned b, input int unsigned w);
    return w - 1 - b;
  endfunction

  typedef enum logic [1:0] {REG_NONE, REG_REQ, REG_STAT} reg_sel_e;
endpackage

// File: rtl/qwk_decode.sv
module qwk_decode
  import qwk_pkg::*;
#(
  parameter int unsigned ADDR_W = 35
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [NCORE-1:0]  core_mask
);
  localparam int unsigned SEL_LO = msb0(SEL_MSB0 + NCORE - 1, IDX_W);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_masked;

  always_comb begin
    idx        = IDX_W'(addr >> 3);
    idx_masked = idx;
    idx_masked[SEL_LO +: NCORE] = '0;
  end

  for (genvar j = 0; j < NCORE; j++) begin : g_mask
    assign core_mask[j] = idx[msb0(SEL_MSB0 + j, IDX_W)];
  end

  always_comb begin
    if (idx_masked == IDX_REQ)       sel = REG_REQ;
    else if (idx_masked == IDX_STAT) sel = REG_STAT;
    else                             sel = REG_NONE;
  end
endmodule

// File: rtl/qwk_state.sv
module qwk_state
  import qwk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NCORE-1:0] mask,
  input  logic             set_val,
  output logic [NCORE-1:0] req_q,
  output logic             done_q
);
  logic [NCORE-1:0] req_d;
  logic             done_d;

  always_comb begin
    req_d  = req_q;
    done_d = done_q;
    if (wr_en) begin
      done_d = set_val;
      for (int j = 0; j < NCORE; j++)
        if (mask[j]) req_d[j] = set_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      done_q <= 1'b0;
    end else if (wr_en) begin
      req_q  <= req_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/qwk_handler.sv
module qwk_handler
  import qwk_pkg::*;
#(
  parameter int unsigned ADDR_W = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCORE-1:0]  wake_req,
  output logic              wake_done,
  output logic              unimpl_err
);
  localparam int unsigned BIT_SET   = msb0(0, DATA_W);
  localparam int unsigned BIT_DONE1 = msb0(1, DATA_W);
  localparam int unsigned BIT_DONE4 = msb0(4, DATA_W);

  reg_sel_e         sel;
  logic [NCORE-1:0] mask;
  logic             wr_req;
  logic [DATA_W-1:0] rdata_d;
  logic             rvalid_d;
  logic             err_d;

  qwk_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (req_addr),
    .sel       (sel),
    .core_mask (mask)
  );

  assign wr_req = req_valid && req_write && (sel == REG_REQ);

  qwk_state u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_req),
    .mask    (mask),
    .set_val (req_wdata[BIT_SET]),
    .req_q   (wake_req),
    .done_q  (wake_done)
  );

  always_comb begin
    rvalid_d = req_valid && !req_write;
    err_d    = req_valid && req_write && (sel == REG_NONE);
    rdata_d  = '1;
    if (sel == REG_STAT) begin
      rdata_d = '0;
      rdata_d[BIT_DONE1] = wake_done;
      rdata_d[BIT_DONE4] = wake_done;
    end else if (sel == REG_REQ) begin
      rdata_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      unimpl_err <= 1'b0;
    end else begin
      rd_valid   <= rvalid_d;
      unimpl_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_data <= '0;
    else if (rvalid_d) rd_data <= rdata_d;
  end
endmodule

// File: rtl/qwk_handler_chk.sv
module qwk_handler_chk
  import qwk_pkg::*;
#(
  parameter int unsigned ADDR_W = 35
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rd_valid,
  input logic [NCORE-1:0]  wake_req,
  input logic              wake_done,
  input logic              unimpl_err
);
  logic req_hit;
  logic [IDX_W-1:0] ci;
  always_comb begin
    ci = IDX_W'(req_addr >> 3);
    ci[15:12] = 4'h0;
    req_hit = (ci == IDX_REQ);
  end

  // R8
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  // R8
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);

  // R4
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_hit) |=> (wake_done == $past(req_wdata[63])));

  // R7
  unimpl_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_hit) |=> ($stable(wake_req) && $stable(wake_done)));

  // R7
  unimpl_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> !unimpl_err);

  // R3
  unselected_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[17:15] == 3'b000 && req_addr[14] == 1'b0)
      |=> wake_req[3] == $past(wake_req[3]));
endmodule

bind qwk_handler qwk_handler_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rd_valid   (rd_valid),
  .wake_req   (wake_req),
  .wake_done  (wake_done),
  .unimpl_err (unimpl_err)
);

// File: tb/tb_qwk_handler.sv
module tb_qwk_handler;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [34:0] req_addr;
  logic [63:0] req_wdata;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [3:0]  wake_req;
  logic        wake_done, unimpl_err;

  int n_run = 0, n_fail = 0;
  logic [3:0] exp_req;
  logic       exp_done;

  always #5 clk = ~clk;

  qwk_handler dut (.*);

  localparam logic [63:0] SETB = 64'h8000_0000_0000_0000;
  localparam logic [63:0] STAT_ON = 64'h4800_0000_0000_0000;

  // {mask(4), set(1), expected wake_req(4), expected done(1)}
  localparam int NV = 6;
  localparam logic [9:0] VEC [NV] = '{
    {4'b0001, 1'b1, 4'b0001, 1'b1},
    {4'b1010, 1'b1, 4'b1011, 1'b1},
    {4'b0001, 1'b0, 4'b1010, 1'b0},
    {4'b0000, 1'b1, 4'b1010, 1'b1},
    {4'b1111, 1'b0, 4'b0000, 1'b0},
    {4'b0100, 1'b1, 4'b0100, 1'b1}
  };

  function automatic logic [34:0] mk_addr(input logic [31:0] idx, input logic [3:0] m);
    logic [31:0] i;
    i = idx;
    for (int j = 0; j < 4; j++) i[15-j] = m[j];
    return {i, 3'b000};
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [34:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 wake_req", {60'b0, wake_req}, 64'h0);
    chk("R1 flags", {61'b0, wake_done, rd_valid, unimpl_err}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 table walk
    for (int k = 0; k < NV; k++) begin
      access(1'b1, mk_addr(32'h83c, VEC[k][9:6]), VEC[k][5] ? SETB : 64'h0);
      chk("R3 wake_req", {60'b0, wake_req}, {60'b0, VEC[k][4:1]});
      chk("R4 done", {63'b0, wake_done}, {63'b0, VEC[k][0]});
      chk("R7 no err on known", {63'b0, unimpl_err}, 64'h0);
    end
    exp_req = 4'b0100; exp_done = 1'b1;

    // R5 status with done set, with R8 timing
    access(1'b0, mk_addr(32'h82c, 4'b0000), 64'h0);
    chk("R8 rd_valid", {63'b0, rd_valid}, 64'h1);
    chk("R5 status on", rd_data, STAT_ON);
    @(negedge clk);
    chk("R8 valid one cycle", {63'b0, rd_valid}, 64'h0);

    // R2 status decode with mask nibble set
    access(1'b0, mk_addr(32'h82c, 4'b1001), 64'h0);
    chk("R2 masked status", rd_data, STAT_ON);

    // R6 unknown read
    access(1'b0, mk_addr(32'h123, 4'b0000), 64'h0);
    chk("R6 unknown read", rd_data, 64'hFFFF_FFFF_FFFF_FFFF);

    // R7 unknown write
    access(1'b1, mk_addr(32'h83d, 4'b1111), 64'h0);
    chk("R7 err pulse", {63'b0, unimpl_err}, 64'h1);
    chk("R7 state kept", {59'b0, wake_done, wake_req}, {59'b0, exp_done, exp_req});
    @(negedge clk);
    chk("R7 err one cycle", {63'b0, unimpl_err}, 64'h0);

    // R5 status with done clear
    access(1'b1, mk_addr(32'h83c, 4'b0000), 64'h0);
    access(1'b0, mk_addr(32'h82c, 4'b0000), 64'h0);
    chk("R5 status off", rd_data, 64'h0);
    chk("R4 mask zero keeps req", {60'b0, wake_req}, 64'h4);

    // R3 ignores other data bits
    access(1'b1, mk_addr(32'h83c, 4'b0010), 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R3 other bits ignored", {60'b0, wake_req}, 64'h4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule